// File: doc/BRIEF.md
# Fastlock Wide-Bandwidth Window Timer

This block sits beside a fractional-N synthesizer loop and times a short acquisition phase after every change of the output frequency. When the frequency register is written, the block opens a window of a programmed number of phase-detector clock cycles. While the window is open, the block asks the charge pump for a boosted current (sixteen times normal by default). It also enables an open-drain style switch that grounds part of the loop-filter damping resistor, so the loop stays stable at the higher bandwidth. When the count runs out, both controls return to normal together and the loop settles in its narrow-bandwidth configuration.

The block is clocked at the phase-detector rate, so one count is one reference cycle. A 40 µs window at a 13 MHz comparison rate therefore takes the value 520. A two-bit mode field selects the behaviour. Only the switched-fastlock code opens windows; every other code keeps the block idle. The timer value and mode are static configuration, and only the write strobe starts or restarts a window.

Top module: `fastlock_bw_timer`

## Requirements
- R1: While reset is asserted (rst_n low), wide_bw_active is 0, cp_gain_sel holds the normal code 1 and sw_gnd_en is 0.
- R2: A freq_wr_stb sampled on a rising edge while mode_sel equals binary 01 and timer_val is nonzero sets wide_bw_active from that same edge.
- R3: The window lasts exactly timer_val clock cycles, measured from the strobe edge (for example 520, 1 and 4095 cycles).
- R4: cp_gain_sel equals 16 (binary 10000, one shifted left by 4) in every cycle the window is open, and equals 1 in every other cycle.
- R5: sw_gnd_en is 1 exactly in the cycles the window is open. It rises and falls on the same edges as wide_bw_active.
- R6: A strobe while mode_sel is 00, 10 or 11 opens no window.
- R7: A strobe while timer_val is 0 opens no window. If a window is running, it ends on that edge.
- R8: A qualifying strobe during an open window restarts the count, so the window then lasts timer_val cycles from the new strobe.
- R9: If mode_sel leaves 01 while a window is open, the window ends on the next rising edge.
- R10: A change of timer_val with no strobe does not alter the length of a running window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase-detector rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | MODE_W (2) | Fastlock mode field; 01 enables switched fastlock |
| timer_val | input | CNT_W (12) | Window length in reference cycles |
| freq_wr_stb | input | 1 | One-cycle pulse on a frequency register write |
| wide_bw_active | output | 1 | High while the wide-bandwidth window is open |
| cp_gain_sel | output | GAIN_W (5) | Charge-pump current multiplier: 1 normal, 2**BOOST_LOG2 in window |
| sw_gnd_en | output | 1 | Enables the pull-to-ground of the loop-filter switch |

## Verification
The bench builds the block with its default parameters: a 12-bit count, a two-bit mode field and a boost exponent of 4. These defaults bring the full-scale window of 4095 cycles and the worked 520-cycle example within a short run. With the full 12-bit width, the bench can measure the single-cycle window, the largest window and a restart at mid-count exactly. Under the same build it also checks that the gain code 16 and the switch track the window on every cycle.

// File: rtl/fl_pkg.sv
package fl_pkg;

   // Command presented to the window counter each cycle.
   typedef enum logic [1:0] {
      FL_CMD_HOLD  = 2'd0,
      FL_CMD_LOAD  = 2'd1,
      FL_CMD_CLEAR = 2'd2
   } fl_cmd_e;

   function automatic int unsigned fl_gain_width(input int unsigned boost_log2);
      return boost_log2 + 1;
   endfunction

endpackage

// File: rtl/fl_mode_match.sv
module fl_mode_match #(
   parameter int          MODE_W      = 2,
   parameter logic [MODE_W-1:0] SWITCHED_CODE = 2'b01,
   parameter int          CNT_W       = 12
) (
   input  logic [MODE_W-1:0] mode_sel,
   input  logic [CNT_W-1:0]  timer_val,
   input  logic              freq_wr_stb,
   output fl_pkg::fl_cmd_e   cmd
);
   import fl_pkg::*;

   logic mode_ok;
   logic val_zero;

   assign mode_ok  = (mode_sel == SWITCHED_CODE);
   assign val_zero = (timer_val == '0);

   always_comb begin
      if (!mode_ok)
         cmd = FL_CMD_CLEAR;
      else if (freq_wr_stb)
         cmd = val_zero ? FL_CMD_CLEAR : FL_CMD_LOAD;
      else
         cmd = FL_CMD_HOLD;
   end

endmodule

// File: rtl/fl_window_counter.sv
module fl_window_counter #(
   parameter int CNT_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  fl_pkg::fl_cmd_e cmd,
   input  logic [CNT_W-1:0] load_val,
   output logic            active
);
   import fl_pkg::*;

   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
         active <= 1'b0;
      end else begin
         unique case (cmd)
            FL_CMD_CLEAR: begin
               remain <= '0;
               active <= 1'b0;
            end
            FL_CMD_LOAD: begin
               remain <= load_val;
               active <= 1'b1;
            end
            default: begin
               if (active) begin
                  if (remain == LAST) begin
                     remain <= '0;
                     active <= 1'b0;
                  end else begin
                     remain <= remain - LAST;
                  end
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/fl_gain_switch.sv
module fl_gain_switch #(
   parameter int BOOST_LOG2 = 4,
   parameter int GAIN_W     = BOOST_LOG2 + 1
) (
   input  logic              active,
   output logic [GAIN_W-1:0] gain_sel,
   output logic              gnd_en
);
   localparam logic [GAIN_W-1:0] GAIN_NORM  = GAIN_W'(1);
   localparam logic [GAIN_W-1:0] GAIN_BOOST = GAIN_W'(1) << BOOST_LOG2;

   generate
      if (BOOST_LOG2 == 0) begin : g_flat
         assign gain_sel = GAIN_NORM;
      end else begin : g_boost
         assign gain_sel = active ? GAIN_BOOST : GAIN_NORM;
      end
   endgenerate

   assign gnd_en = active;

endmodule

// File: rtl/fastlock_bw_timer.sv
module fastlock_bw_timer #(
   parameter int          CNT_W         = 12,
   parameter int          MODE_W        = 2,
   parameter logic [MODE_W-1:0] SWITCHED_CODE = 2'b01,
   parameter int          BOOST_LOG2    = 4,
   localparam int         GAIN_W        = BOOST_LOG2 + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_sel,
   input  logic [CNT_W-1:0]  timer_val,
   input  logic              freq_wr_stb,
   output logic              wide_bw_active,
   output logic [GAIN_W-1:0] cp_gain_sel,
   output logic              sw_gnd_en
);
   import fl_pkg::*;

   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("fastlock_bw_timer: CNT_W must be 1..32");
   end
   if (MODE_W < 1) begin : g_bad_mode
      $error("fastlock_bw_timer: MODE_W must be at least 1");
   end
   if (BOOST_LOG2 < 0 || BOOST_LOG2 > 15) begin : g_bad_boost
      $error("fastlock_bw_timer: BOOST_LOG2 must be 0..15");
   end
   if (GAIN_W != fl_gain_width(BOOST_LOG2)) begin : g_bad_gain
      $error("fastlock_bw_timer: gain width mismatch");
   end

   fl_cmd_e cmd;
   logic    active;

   fl_mode_match #(
      .MODE_W        (MODE_W),
      .SWITCHED_CODE (SWITCHED_CODE),
      .CNT_W         (CNT_W)
   ) u_match (
      .mode_sel    (mode_sel),
      .timer_val   (timer_val),
      .freq_wr_stb (freq_wr_stb),
      .cmd         (cmd)
   );

   fl_window_counter #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .load_val (timer_val),
      .active   (active)
   );

   fl_gain_switch #(
      .BOOST_LOG2 (BOOST_LOG2),
      .GAIN_W     (GAIN_W)
   ) u_out (
      .active   (active),
      .gain_sel (cp_gain_sel),
      .gnd_en   (sw_gnd_en)
   );

   assign wide_bw_active = active;

endmodule

// File: rtl/fastlock_bw_timer_chk.sv
module fastlock_bw_timer_chk #(
   parameter int          CNT_W         = 12,
   parameter int          MODE_W        = 2,
   parameter logic [MODE_W-1:0] SWITCHED_CODE = 2'b01,
   parameter int          BOOST_LOG2    = 4,
   localparam int         GAIN_W        = BOOST_LOG2 + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [MODE_W-1:0] mode_sel,
   input logic [CNT_W-1:0]  timer_val,
   input logic              freq_wr_stb,
   input logic              wide_bw_active,
   input logic [GAIN_W-1:0] cp_gain_sel,
   input logic              sw_gnd_en
);
   localparam logic [GAIN_W-1:0] G_NORM  = GAIN_W'(1);
   localparam logic [GAIN_W-1:0] G_BOOST = GAIN_W'(1) << BOOST_LOG2;

   // Countdown mirror kept in the checker to bound the window length.
   logic [CNT_W-1:0] exp_left;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         exp_left <= '0;
      else if (mode_sel != SWITCHED_CODE)
         exp_left <= '0;
      else if (freq_wr_stb)
         exp_left <= timer_val;
      else if (exp_left != '0)
         exp_left <= exp_left - CNT_W'(1);
   end

   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |-> (!wide_bw_active && cp_gain_sel == G_NORM && !sw_gnd_en));

   p_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_wr_stb && mode_sel == SWITCHED_CODE && timer_val != '0) |=> wide_bw_active);

   p_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wide_bw_active == (exp_left != '0));

   p_gain_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cp_gain_sel == (wide_bw_active ? G_BOOST : G_NORM));

   p_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sw_gnd_en == wide_bw_active);

   p_ignore_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_wr_stb && mode_sel != SWITCHED_CODE) |=> !wide_bw_active);

   p_zero_val_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_wr_stb && timer_val == '0) |=> !wide_bw_active);

   p_mode_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel != SWITCHED_CODE) |=> !wide_bw_active);

endmodule

bind fastlock_bw_timer fastlock_bw_timer_chk #(
   .CNT_W         (CNT_W),
   .MODE_W        (MODE_W),
   .SWITCHED_CODE (SWITCHED_CODE),
   .BOOST_LOG2    (BOOST_LOG2)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .mode_sel       (mode_sel),
   .timer_val      (timer_val),
   .freq_wr_stb    (freq_wr_stb),
   .wide_bw_active (wide_bw_active),
   .cp_gain_sel    (cp_gain_sel),
   .sw_gnd_en      (sw_gnd_en)
);

// File: tb/fastlock_bw_timer_tb_top.sv
module fastlock_bw_timer_tb_top;

   localparam int CNT_W = 12;
   localparam int GAIN_W = 5;
   localparam logic [GAIN_W-1:0] G_NORM = 5'd1;
   localparam logic [GAIN_W-1:0] G_BOOST = 5'd16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        mode_sel = 2'b01;
   logic [CNT_W-1:0]  timer_val = '0;
   logic              freq_wr_stb = 1'b0;
   logic              wide_bw_active;
   logic [GAIN_W-1:0] cp_gain_sel;
   logic              sw_gnd_en;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   fastlock_bw_timer dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .mode_sel       (mode_sel),
      .timer_val      (timer_val),
      .freq_wr_stb    (freq_wr_stb),
      .wide_bw_active (wide_bw_active),
      .cp_gain_sel    (cp_gain_sel),
      .sw_gnd_en      (sw_gnd_en)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Drive a one-cycle strobe; returns at the negedge after the sampling edge.
   task automatic strobe();
      @(negedge clk);
      freq_wr_stb = 1'b1;
      @(negedge clk);
      freq_wr_stb = 1'b0;
   endtask

   // Counts open-window cycles from the current negedge; checks R4/R5 each cycle.
   task automatic measure(input int change_at, input logic [CNT_W-1:0] new_val,
                          output int n, output int bad_out);
      n = 0;
      bad_out = 0;
      while (wide_bw_active && n < 5000) begin
         if (cp_gain_sel != G_BOOST || sw_gnd_en != 1'b1) bad_out++;
         n++;
         if (n == change_at) timer_val = new_val;
         @(negedge clk);
      end
      if (cp_gain_sel != G_NORM || sw_gnd_en != 1'b0) bad_out++;
   endtask

   task automatic t_reset();
      check(wide_bw_active == 1'b0, "R1 active in reset", int'(wide_bw_active), 0);
      check(cp_gain_sel == G_NORM, "R1 gain in reset", int'(cp_gain_sel), 1);
      check(sw_gnd_en == 1'b0, "R1 switch in reset", int'(sw_gnd_en), 0);
   endtask

   task automatic t_window(input logic [CNT_W-1:0] len, input string tag);
      int n, bad;
      mode_sel = 2'b01;
      timer_val = len;
      strobe();
      check(wide_bw_active == 1'b1, {tag, " R2 opens on strobe edge"}, int'(wide_bw_active), 1);
      measure(0, '0, n, bad);
      check(n == int'(len), {tag, " R3 window length"}, n, int'(len));
      check(bad == 0, {tag, " R4 R5 gain and switch track window"}, bad, 0);
   endtask

   task automatic t_other_modes();
      mode_sel = 2'b00;
      timer_val = 12'd30;
      strobe();
      check(wide_bw_active == 1'b0, "R6 mode 00 ignored", int'(wide_bw_active), 0);
      mode_sel = 2'b10;
      strobe();
      check(wide_bw_active == 1'b0, "R6 mode 10 ignored", int'(wide_bw_active), 0);
      mode_sel = 2'b11;
      strobe();
      repeat (3) @(negedge clk);
      check(wide_bw_active == 1'b0 && cp_gain_sel == G_NORM && sw_gnd_en == 1'b0,
            "R6 mode 11 ignored", int'(cp_gain_sel), 1);
      mode_sel = 2'b01;
   endtask

   task automatic t_zero();
      timer_val = '0;
      strobe();
      check(wide_bw_active == 1'b0, "R7 zero value no window", int'(wide_bw_active), 0);
      timer_val = 12'd40;
      strobe();
      repeat (5) @(negedge clk);
      timer_val = '0;
      strobe();
      check(wide_bw_active == 1'b0 && sw_gnd_en == 1'b0, "R7 zero strobe ends window",
            int'(wide_bw_active), 0);
   endtask

   task automatic t_restart();
      int n, bad;
      timer_val = 12'd25;
      strobe();
      repeat (10) @(negedge clk);
      strobe();
      measure(0, '0, n, bad);
      check(n == 25, "R8 restart gives full length", n, 25);
      check(bad == 0, "R8 outputs during restart", bad, 0);
   endtask

   task automatic t_mode_exit();
      timer_val = 12'd100;
      strobe();
      repeat (5) @(negedge clk);
      mode_sel = 2'b00;
      @(negedge clk);
      check(wide_bw_active == 1'b0 && cp_gain_sel == G_NORM, "R9 mode exit ends window",
            int'(wide_bw_active), 0);
      mode_sel = 2'b01;
   endtask

   task automatic t_value_change();
      int n, bad;
      timer_val = 12'd50;
      strobe();
      measure(10, 12'd7, n, bad);
      check(n == 50, "R10 value change without strobe", n, 50);
   endtask

   task automatic t_reset_mid();
      timer_val = 12'd200;
      strobe();
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(wide_bw_active == 1'b0 && sw_gnd_en == 1'b0 && cp_gain_sel == G_NORM,
            "R1 reset mid-window", int'(wide_bw_active), 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_window(12'd520, "w520");
      t_window(12'd1, "w1");
      t_window(12'd4095, "w4095");
      t_window(12'd3, "w3");
      t_other_modes();
      t_zero();
      t_restart();
      t_mode_exit();
      t_value_change();
      t_reset_mid();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(20 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule